// File: doc/BRIEF.md
# Hierarchical Coherence Directory Node

This block is one node in a tree of coherence directories that sits above a set of attraction memories. It stores no data. For every tracked item it keeps a state and an address tag. It sits between an upper bus and a lower bus. Each transaction that arrives from below is either settled inside the node's own subtree or passed upward. Transactions that arrive from above are passed down into the subtree when they concern an item the node tracks. The node combines concurrent reads. It carries erases up to the root, where racing erases are settled by arrival order. At the root, an unresolved out transaction is turned into an inject.

The parameter `IS_TOP` marks the root node. A root node ignores its upper bus and never drives it. The directory is direct-mapped and indexed by the low `IDX_W` address bits. A lookup hits when the stored tag matches and the state is not Invalid. An allocation overwrites the indexed entry.

Transaction codes, on 3 bits: READ=0, DATA=1, ERASE=2, EXCL (exclusive acknowledge)=3, OUT=4, INJECT=5.

Per-item states: INV (invalid), SHR (shared below), EXC (exclusive below), RDG (reading, request sent up), ANS (answering a read from below), AUP (answering a read from above), WTG (waiting for the exclusive acknowledge), RWT (reading and waiting, lost an erase race).

Transitions on a transaction from below:
- READ: INV→RDG, and the read is sent up. SHR/EXC→ANS. WTG→RWT. RDG/ANS/AUP/RWT are unchanged.
- DATA: ANS→SHR. AUP→SHR, and the data is sent up.
- ERASE at a non-root node: any state→WTG, and the erase is sent up.
- ERASE at the root: EXC stays EXC, and an ERASE is sent down. Any other state→EXC, and an EXCL is sent down.
- OUT: absorbed in SHR/RDG/WTG/RWT. In any other state it sets a hit entry to INV. A non-root node then sends the OUT up; the root sends an INJECT down.

Transitions on a transaction from above (non-root only):
- READ: SHR/EXC→AUP, and the read is relayed down.
- DATA: RDG→SHR and RWT→WTG, each with the data relayed down.
- ERASE: WTG→RWT and RWT→RWT, each with an ERASE relayed down. Any other hit state→INV, with an ERASE relayed down.
- EXCL: WTG→EXC, with an EXCL relayed down. Any other hit state→INV, with an ERASE relayed down.
- INJECT: the entry is allocated as SHR, and the INJECT is relayed down.

Top module: `dir_node`

## Requirements
- R1: Reset drives up_vld and dn_vld low and clears every entry to INV, so a following READ from below for any item is sent up.
- R2: A READ from below that misses is sent up once on the next cycle with the same address. Further READs for that item while it is RDG produce no output.
- R3: A READ from below for an item held SHR produces no output.
- R4: DATA from above for an RDG item is relayed down, and the item becomes SHR.
- R5: After a READ from above for an SHR item, the READ is relayed down and DATA from below is sent up. DATA from below for an item answered locally (ANS) is not sent up.
- R6: At a non-root node an ERASE from below is sent up, and an EXCL from above for the waiting item is relayed down as EXCL.
- R7: An ERASE or EXCL from above for an item held but not waiting is relayed down as ERASE, and the item becomes INV.
- R8: An ERASE from above for a WTG item (a lost race) is relayed down as ERASE. Later DATA from above is relayed down, and a later EXCL is relayed as EXCL.
- R9: An OUT from below is absorbed when the item is SHR, RDG, WTG or RWT. Otherwise a non-root node sends it up and sets the item to INV.
- R10: At the root an unabsorbed OUT is sent down as INJECT, the upper bus inputs are ignored, and up_vld stays low.
- R11: At the root the first ERASE for an item is answered down with EXCL. An ERASE for an item already EXC is turned back down as ERASE.
- R12: An INJECT from above is relayed down, and the item becomes SHR.
- R13: When both buses present a transaction in the same cycle, the one from above updates the directory first, and the one from below sees that result.
- R14: A DATA or EXCL from above for an item with no matching entry produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_vld | input | 1 | Transaction from the upper bus valid |
| hi_op | input | 3 | Upper bus transaction code |
| hi_addr | input | ADDR_W | Upper bus item address |
| lo_vld | input | 1 | Transaction from the lower bus valid |
| lo_op | input | 3 | Lower bus transaction code |
| lo_addr | input | ADDR_W | Lower bus item address |
| up_vld | output | 1 | Transaction to the upper bus valid (registered) |
| up_op | output | 3 | Code sent upward |
| up_addr | output | ADDR_W | Address sent upward |
| dn_vld | output | 1 | Transaction to the lower bus valid (registered) |
| dn_op | output | 3 | Code sent downward |
| dn_addr | output | ADDR_W | Address sent downward |

## Verification
Some properties are checked on every cycle. Each upward or downward emission must be traced to a transaction of the right kind one cycle earlier. EXCL and INJECT must come only from the proper source. A root must stay silent upward. A read sent up must not be sent up again on the next cycle. Other behaviour can only be shown by ordered scenarios in the bench: read combining, the answering paths, the lost-race path through RWT, out absorption, root arbitration and the above-first ordering. These depend on state built up over several transactions.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_DATA   = 3'd1,
        OP_ERASE  = 3'd2,
        OP_EXCL   = 3'd3,
        OP_OUT    = 3'd4,
        OP_INJECT = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        ST_INV = 3'd0,
        ST_SHR = 3'd1,
        ST_EXC = 3'd2,
        ST_RDG = 3'd3,
        ST_ANS = 3'd4,
        ST_AUP = 3'd5,
        ST_WTG = 3'd6,
        ST_RWT = 3'd7
    } st_e;

endpackage

// File: rtl/dir_store.sv
module dir_store
    import dir_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ra_idx,
    output st_e              ra_st,
    output logic [TAG_W-1:0] ra_tag,
    input  logic [IDX_W-1:0] rb_idx,
    output st_e              rb_st,
    output logic [TAG_W-1:0] rb_tag,
    input  logic             wa_en,
    input  logic [IDX_W-1:0] wa_idx,
    input  st_e              wa_st,
    input  logic [TAG_W-1:0] wa_tag,
    input  logic             wb_en,
    input  logic [IDX_W-1:0] wb_idx,
    input  st_e              wb_st,
    input  logic [TAG_W-1:0] wb_tag
);
    localparam int DEPTH = 1 << IDX_W;

    st_e              st_q  [DEPTH];
    logic [TAG_W-1:0] tag_q [DEPTH];

    assign ra_st  = st_q[ra_idx];
    assign ra_tag = tag_q[ra_idx];
    assign rb_st  = st_q[rb_idx];
    assign rb_tag = tag_q[rb_idx];

    // Port b (the lower bus, handled second) wins on an index collision.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_q[i]  <= ST_INV;
                tag_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wb_en && wb_idx == IDX_W'(i)) begin
                    st_q[i]  <= wb_st;
                    tag_q[i] <= wb_tag;
                end else if (wa_en && wa_idx == IDX_W'(i)) begin
                    st_q[i]  <= wa_st;
                    tag_q[i] <= wa_tag;
                end
            end
        end
    end
endmodule

// File: rtl/dir_hi_rule.sv
module dir_hi_rule
    import dir_pkg::*;
(
    input  logic vld,
    input  op_e  op,
    input  logic hit,
    input  st_e  cur,
    output logic we,
    output st_e  nst,
    output logic dn_v,
    output op_e  dn_o
);
    st_e st;

    always_comb begin
        st   = hit ? cur : ST_INV;
        we   = 1'b0;
        nst  = st;
        dn_v = 1'b0;
        dn_o = OP_READ;
        if (vld) begin
            unique case (op)
                OP_READ: begin
                    if (st == ST_SHR || st == ST_EXC) begin
                        we = 1'b1; nst = ST_AUP; dn_v = 1'b1; dn_o = OP_READ;
                    end
                end
                OP_DATA: begin
                    if (st == ST_RDG) begin
                        we = 1'b1; nst = ST_SHR; dn_v = 1'b1; dn_o = OP_DATA;
                    end else if (st == ST_RWT) begin
                        we = 1'b1; nst = ST_WTG; dn_v = 1'b1; dn_o = OP_DATA;
                    end
                end
                OP_ERASE: begin
                    if (st == ST_WTG || st == ST_RWT) begin
                        we = 1'b1; nst = ST_RWT; dn_v = 1'b1; dn_o = OP_ERASE;
                    end else if (st != ST_INV) begin
                        we = 1'b1; nst = ST_INV; dn_v = 1'b1; dn_o = OP_ERASE;
                    end
                end
                OP_EXCL: begin
                    if (st == ST_WTG) begin
                        we = 1'b1; nst = ST_EXC; dn_v = 1'b1; dn_o = OP_EXCL;
                    end else if (st != ST_INV) begin
                        we = 1'b1; nst = ST_INV; dn_v = 1'b1; dn_o = OP_ERASE;
                    end
                end
                OP_INJECT: begin
                    we = 1'b1; nst = ST_SHR; dn_v = 1'b1; dn_o = OP_INJECT;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dir_lo_rule.sv
module dir_lo_rule
    import dir_pkg::*;
#(
    parameter bit IS_TOP = 1'b0
) (
    input  logic vld,
    input  op_e  op,
    input  logic hit,
    input  st_e  cur,
    output logic we,
    output st_e  nst,
    output logic up_v,
    output op_e  up_o,
    output logic dn_v,
    output op_e  dn_o
);
    st_e  st;
    logic keeps_copy;

    always_comb begin
        st         = hit ? cur : ST_INV;
        keeps_copy = (st == ST_SHR) || (st == ST_RDG) || (st == ST_WTG) || (st == ST_RWT);
        we   = 1'b0;
        nst  = st;
        up_v = 1'b0;
        up_o = OP_READ;
        dn_v = 1'b0;
        dn_o = OP_READ;
        if (vld) begin
            unique case (op)
                OP_READ: begin
                    case (st)
                        ST_INV: begin
                            we = 1'b1; nst = ST_RDG;
                            up_v = !IS_TOP; up_o = OP_READ;
                        end
                        ST_SHR, ST_EXC: begin we = 1'b1; nst = ST_ANS; end
                        ST_WTG:         begin we = 1'b1; nst = ST_RWT; end
                        default: ;
                    endcase
                end
                OP_DATA: begin
                    if (st == ST_ANS) begin
                        we = 1'b1; nst = ST_SHR;
                    end else if (st == ST_AUP) begin
                        we = 1'b1; nst = ST_SHR; up_v = !IS_TOP; up_o = OP_DATA;
                    end
                end
                OP_ERASE: begin
                    if (!IS_TOP) begin
                        we = 1'b1; nst = ST_WTG; up_v = 1'b1; up_o = OP_ERASE;
                    end else if (st == ST_EXC) begin
                        dn_v = 1'b1; dn_o = OP_ERASE;
                    end else begin
                        we = 1'b1; nst = ST_EXC; dn_v = 1'b1; dn_o = OP_EXCL;
                    end
                end
                OP_OUT: begin
                    if (!keeps_copy) begin
                        we  = hit;
                        nst = ST_INV;
                        if (IS_TOP) begin
                            dn_v = 1'b1; dn_o = OP_INJECT;
                        end else begin
                            up_v = 1'b1; up_o = OP_OUT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dir_node.sv
module dir_node
    import dir_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter bit IS_TOP = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_vld,
    input  logic [2:0]        hi_op,
    input  logic [ADDR_W-1:0] hi_addr,
    input  logic              lo_vld,
    input  logic [2:0]        lo_op,
    input  logic [ADDR_W-1:0] lo_addr,
    output logic              up_vld,
    output logic [2:0]        up_op,
    output logic [ADDR_W-1:0] up_addr,
    output logic              dn_vld,
    output logic [2:0]        dn_op,
    output logic [ADDR_W-1:0] dn_addr
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic             hi_v_eff;
    logic [IDX_W-1:0] hi_idx, lo_idx;
    logic [TAG_W-1:0] hi_tag, lo_tag;
    st_e              ra_st, rb_st;
    logic [TAG_W-1:0] ra_tag, rb_tag;

    // A root node has nothing above it: its upper bus is ignored.
    generate
        if (IS_TOP) begin : g_root
            assign hi_v_eff = 1'b0;
        end else begin : g_inner
            assign hi_v_eff = hi_vld;
        end
    endgenerate

    assign hi_idx = hi_addr[IDX_W-1:0];
    assign hi_tag = hi_addr[ADDR_W-1:IDX_W];
    assign lo_idx = lo_addr[IDX_W-1:0];
    assign lo_tag = lo_addr[ADDR_W-1:IDX_W];

    // Transaction from above: evaluated first.
    logic hi_hit, hi_we, hi_dn_v;
    st_e  hi_nst;
    op_e  hi_dn_o;

    assign hi_hit = (ra_st != ST_INV) && (ra_tag == hi_tag);

    dir_hi_rule u_hi (
        .vld  (hi_v_eff),
        .op   (op_e'(hi_op)),
        .hit  (hi_hit),
        .cur  (ra_st),
        .we   (hi_we),
        .nst  (hi_nst),
        .dn_v (hi_dn_v),
        .dn_o (hi_dn_o)
    );

    // Transaction from below sees the result of the one from above.
    logic             same_idx, lo_hit, lo_we, lo_up_v, lo_dn_v;
    st_e              lo_cur_st, lo_nst;
    logic [TAG_W-1:0] lo_cur_tag;
    op_e              lo_up_o, lo_dn_o;

    assign same_idx   = hi_we && (hi_idx == lo_idx);
    assign lo_cur_st  = same_idx ? hi_nst : rb_st;
    assign lo_cur_tag = same_idx ? hi_tag : rb_tag;
    assign lo_hit     = (lo_cur_st != ST_INV) && (lo_cur_tag == lo_tag);

    dir_lo_rule #(.IS_TOP(IS_TOP)) u_lo (
        .vld  (lo_vld),
        .op   (op_e'(lo_op)),
        .hit  (lo_hit),
        .cur  (lo_cur_st),
        .we   (lo_we),
        .nst  (lo_nst),
        .up_v (lo_up_v),
        .up_o (lo_up_o),
        .dn_v (lo_dn_v),
        .dn_o (lo_dn_o)
    );

    dir_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_idx (hi_idx),
        .ra_st  (ra_st),
        .ra_tag (ra_tag),
        .rb_idx (lo_idx),
        .rb_st  (rb_st),
        .rb_tag (rb_tag),
        .wa_en  (hi_we),
        .wa_idx (hi_idx),
        .wa_st  (hi_nst),
        .wa_tag (hi_tag),
        .wb_en  (lo_we),
        .wb_idx (lo_idx),
        .wb_st  (lo_nst),
        .wb_tag (lo_tag)
    );

    // Registered bus outputs. The downward sources never collide:
    // hi_dn_v exists only at inner nodes and lo_dn_v only at the root.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_vld  <= 1'b0;
            up_op   <= '0;
            up_addr <= '0;
            dn_vld  <= 1'b0;
            dn_op   <= '0;
            dn_addr <= '0;
        end else begin
            up_vld  <= lo_up_v;
            up_op   <= lo_up_o;
            up_addr <= lo_addr;
            dn_vld  <= hi_dn_v || lo_dn_v;
            dn_op   <= hi_dn_v ? hi_dn_o : lo_dn_o;
            dn_addr <= hi_dn_v ? hi_addr : lo_addr;
        end
    end
endmodule

// File: rtl/dir_node_chk.sv
module dir_node_chk #(
    parameter int ADDR_W = 8,
    parameter bit IS_TOP = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hi_vld,
    input logic [2:0]        hi_op,
    input logic              lo_vld,
    input logic [2:0]        lo_op,
    input logic              up_vld,
    input logic [2:0]        up_op,
    input logic [ADDR_W-1:0] up_addr,
    input logic              dn_vld,
    input logic [2:0]        dn_op
);
    AST_UP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        up_vld |-> $past(lo_vld)); // R2

    AST_ROOT_UP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !(IS_TOP && up_vld)); // R10

    AST_READ_NOT_REPEATED: assert property (@(posedge clk) disable iff (!rst_n)
        (up_vld && up_op == 3'd0 && !hi_vld) |=>
            !(up_vld && up_op == 3'd0 && up_addr == $past(up_addr))); // R2

    AST_EXCL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_vld && dn_op == 3'd3) |->
            ($past(hi_vld && hi_op == 3'd3) || $past(lo_vld && lo_op == 3'd2))); // R6

    AST_INJECT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_vld && dn_op == 3'd5) |->
            ($past(hi_vld && hi_op == 3'd5) || $past(lo_vld && lo_op == 3'd4))); // R12

    AST_DN_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        dn_vld |-> ($past(hi_vld) || (IS_TOP && $past(lo_vld)))); // R11
endmodule

bind dir_node dir_node_chk #(.ADDR_W(ADDR_W), .IS_TOP(IS_TOP)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hi_vld  (hi_vld),
    .hi_op   (hi_op),
    .lo_vld  (lo_vld),
    .lo_op   (lo_op),
    .up_vld  (up_vld),
    .up_op   (up_op),
    .up_addr (up_addr),
    .dn_vld  (dn_vld),
    .dn_op   (dn_op)
);

// File: tb/dir_node_tb_top.sv
module dir_node_tb_top;
    localparam logic [2:0] RD = 3'd0, DA = 3'd1, ER = 3'd2, EX = 3'd3, OU = 3'd4, IN = 3'd5;
    localparam logic [7:0] A = 8'h10, B = 8'h21, C = 8'h42, D = 8'h83, E = 8'h14;

    typedef struct packed {
        logic       hv;  logic [2:0] ho; logic [7:0] ha;
        logic       lv;  logic [2:0] lo; logic [7:0] la;
        logic       euv; logic [2:0] euo;
        logic       edv; logic [2:0] edo;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VT [NV] = '{
        '{1'b0,RD,8'h0, 1'b1,RD,A, 1'b1,RD, 1'b0,RD, 4'd2},  // R2 miss goes up
        '{1'b0,RD,8'h0, 1'b1,RD,A, 1'b0,RD, 1'b0,RD, 4'd2},  // R2 combined
        '{1'b1,DA,A, 1'b0,RD,8'h0, 1'b0,RD, 1'b1,DA, 4'd4},  // R4
        '{1'b0,RD,8'h0, 1'b1,RD,A, 1'b0,RD, 1'b0,RD, 4'd3},  // R3 local answer
        '{1'b0,RD,8'h0, 1'b1,DA,A, 1'b0,RD, 1'b0,RD, 4'd5},  // R5 ANS data stays
        '{1'b1,RD,A, 1'b0,RD,8'h0, 1'b0,RD, 1'b1,RD, 4'd5},  // R5 read from above
        '{1'b0,RD,8'h0, 1'b1,DA,A, 1'b1,DA, 1'b0,RD, 4'd5},  // R5 AUP data up
        '{1'b0,RD,8'h0, 1'b1,ER,B, 1'b1,ER, 1'b0,RD, 4'd6},  // R6
        '{1'b1,EX,B, 1'b0,RD,8'h0, 1'b0,RD, 1'b1,EX, 4'd6},  // R6
        '{1'b1,ER,A, 1'b0,RD,8'h0, 1'b0,RD, 1'b1,ER, 4'd7},  // R7
        '{1'b0,RD,8'h0, 1'b1,RD,A, 1'b1,RD, 1'b0,RD, 4'd7},  // R7 now invalid
        '{1'b1,DA,A, 1'b0,RD,8'h0, 1'b0,RD, 1'b1,DA, 4'd4},  // R4
        '{1'b1,EX,A, 1'b0,RD,8'h0, 1'b0,RD, 1'b1,ER, 4'd7},  // R7 excl on shared
        '{1'b1,EX,C, 1'b0,RD,8'h0, 1'b0,RD, 1'b0,RD, 4'd14}, // R14
        '{1'b1,DA,C, 1'b0,RD,8'h0, 1'b0,RD, 1'b0,RD, 4'd14}, // R14
        '{1'b0,RD,8'h0, 1'b1,ER,C, 1'b1,ER, 1'b0,RD, 4'd6},  // R6
        '{1'b1,ER,C, 1'b0,RD,8'h0, 1'b0,RD, 1'b1,ER, 4'd8},  // R8 lost race
        '{1'b1,DA,C, 1'b0,RD,8'h0, 1'b0,RD, 1'b1,DA, 4'd8},  // R8
        '{1'b1,EX,C, 1'b0,RD,8'h0, 1'b0,RD, 1'b1,EX, 4'd8},  // R8
        '{1'b0,RD,8'h0, 1'b1,OU,C, 1'b1,OU, 1'b0,RD, 4'd9},  // R9 exclusive leaves
        '{1'b0,RD,8'h0, 1'b1,RD,C, 1'b1,RD, 1'b0,RD, 4'd9},  // R9 was invalidated
        '{1'b0,RD,8'h0, 1'b1,OU,C, 1'b0,RD, 1'b0,RD, 4'd9},  // R9 absorbed
        '{1'b1,IN,D, 1'b0,RD,8'h0, 1'b0,RD, 1'b1,IN, 4'd12}, // R12
        '{1'b0,RD,8'h0, 1'b1,RD,D, 1'b0,RD, 1'b0,RD, 4'd12}, // R12 shared now
        '{1'b0,RD,8'h0, 1'b1,OU,B, 1'b1,OU, 1'b0,RD, 4'd9},  // R9
        '{1'b1,IN,A, 1'b0,RD,8'h0, 1'b0,RD, 1'b1,IN, 4'd12}, // R12
        '{1'b1,ER,A, 1'b1,RD,A, 1'b1,RD, 1'b1,ER, 4'd13},    // R13 above first
        '{1'b1,DA,A, 1'b1,ER,A, 1'b1,ER, 1'b1,DA, 4'd13},    // R13
        '{1'b0,RD,8'h0, 1'b1,RD,E, 1'b1,RD, 1'b0,RD, 4'd2}   // R2 tag mismatch
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       hi_vld = 0, lo_vld = 0, t_hi_vld = 0, t_lo_vld = 0;
    logic [2:0] hi_op = 0, lo_op = 0, t_hi_op = 0, t_lo_op = 0;
    logic [7:0] hi_addr = 0, lo_addr = 0, t_hi_addr = 0, t_lo_addr = 0;
    logic       up_vld, dn_vld, t_up_vld, t_dn_vld;
    logic [2:0] up_op, dn_op, t_up_op, t_dn_op;
    logic [7:0] up_addr, dn_addr, t_up_addr, t_dn_addr;

    dir_node #(.ADDR_W(8), .IDX_W(2), .IS_TOP(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .hi_vld(hi_vld), .hi_op(hi_op), .hi_addr(hi_addr),
        .lo_vld(lo_vld), .lo_op(lo_op), .lo_addr(lo_addr),
        .up_vld(up_vld), .up_op(up_op), .up_addr(up_addr),
        .dn_vld(dn_vld), .dn_op(dn_op), .dn_addr(dn_addr));

    dir_node #(.ADDR_W(8), .IDX_W(2), .IS_TOP(1'b1)) root_i (
        .clk(clk), .rst_n(rst_n),
        .hi_vld(t_hi_vld), .hi_op(t_hi_op), .hi_addr(t_hi_addr),
        .lo_vld(t_lo_vld), .lo_op(t_lo_op), .lo_addr(t_lo_addr),
        .up_vld(t_up_vld), .up_op(t_up_op), .up_addr(t_up_addr),
        .dn_vld(t_dn_vld), .dn_op(t_dn_op), .dn_addr(t_dn_addr));

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 0;

    task automatic compare(input string req,
                           input logic uv, input logic [2:0] uo, input logic [7:0] ua,
                           input logic dv, input logic [2:0] dox, input logic [7:0] da,
                           input logic euv, input logic [2:0] euo, input logic [7:0] eua,
                           input logic edv, input logic [2:0] edo, input logic [7:0] eda);
        bit bad;
        bad = (uv !== euv) || (euv && (uo !== euo || ua !== eua)) ||
              (dv !== edv) || (edv && (dox !== edo || da !== eda));
        n_vec++;
        if (bad) begin
            n_bad++;
            $display("FAIL %s: up=%b/%0d/%h dn=%b/%0d/%h expected up=%b/%0d/%h dn=%b/%0d/%h",
                     req, uv, uo, ua, dv, dox, da, euv, euo, eua, edv, edo, eda);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        hi_vld = 0; lo_vld = 0; t_hi_vld = 0; t_lo_vld = 0;
    endtask

    task automatic root_drive(input logic hv, input logic [2:0] ho, input logic [7:0] ha,
                              input logic lv, input logic [2:0] lo, input logic [7:0] la);
        t_hi_vld = hv; t_hi_op = ho; t_hi_addr = ha;
        t_lo_vld = lv; t_lo_op = lo; t_lo_addr = la;
        step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state of both instances
        compare("R1", up_vld, up_op, up_addr, dn_vld, dn_op, dn_addr, 0, 0, 0, 0, 0, 0);
        compare("R1", t_up_vld, t_up_op, t_up_addr, t_dn_vld, t_dn_op, t_dn_addr, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VT[i];
            hi_vld = v.hv; hi_op = v.ho; hi_addr = v.ha;
            lo_vld = v.lv; lo_op = v.lo; lo_addr = v.la;
            step();
            compare($sformatf("R%0d vec %0d", v.req, i), up_vld, up_op, up_addr,
                    dn_vld, dn_op, dn_addr, v.euv, v.euo, v.la, v.edv, v.edo, v.ha);
        end
        idle_inputs();
        step();

        // R1: reset in mid-run clears outputs and entries (D was held)
        rst_n = 1'b0;
        @(negedge clk);
        compare("R1", up_vld, up_op, up_addr, dn_vld, dn_op, dn_addr, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        lo_vld = 1; lo_op = RD; lo_addr = D;
        step();
        compare("R1", up_vld, up_op, up_addr, dn_vld, dn_op, dn_addr, 1, RD, D, 0, 0, 0);
        idle_inputs();

        // R11: root arbitration of erases
        root_drive(0, RD, 0, 1, ER, A);
        compare("R11", t_up_vld, t_up_op, t_up_addr, t_dn_vld, t_dn_op, t_dn_addr, 0, 0, 0, 1, EX, A);
        root_drive(0, RD, 0, 1, ER, A);
        compare("R11", t_up_vld, t_up_op, t_up_addr, t_dn_vld, t_dn_op, t_dn_addr, 0, 0, 0, 1, ER, A);
        // R10: unresolved out becomes inject
        root_drive(0, RD, 0, 1, OU, B);
        compare("R10", t_up_vld, t_up_op, t_up_addr, t_dn_vld, t_dn_op, t_dn_addr, 0, 0, 0, 1, IN, B);
        // R9: at the root a read miss is held silently, then an out is absorbed
        root_drive(0, RD, 0, 1, RD, C);
        compare("R9", t_up_vld, t_up_op, t_up_addr, t_dn_vld, t_dn_op, t_dn_addr, 0, 0, 0, 0, 0, 0);
        root_drive(0, RD, 0, 1, OU, C);
        compare("R9", t_up_vld, t_up_op, t_up_addr, t_dn_vld, t_dn_op, t_dn_addr, 0, 0, 0, 0, 0, 0);
        // R10: upper bus ignored at the root
        root_drive(1, ER, C, 0, RD, 0);
        compare("R10", t_up_vld, t_up_op, t_up_addr, t_dn_vld, t_dn_op, t_dn_addr, 0, 0, 0, 0, 0, 0);
        root_drive(1, IN, D, 0, RD, 0);
        compare("R10", t_up_vld, t_up_op, t_up_addr, t_dn_vld, t_dn_op, t_dn_addr, 0, 0, 0, 0, 0, 0);
        // R10: last exclusive copy leaves the tree and is re-homed
        root_drive(0, RD, 0, 1, OU, A);
        compare("R10", t_up_vld, t_up_op, t_up_addr, t_dn_vld, t_dn_op, t_dn_addr, 0, 0, 0, 1, IN, A);
        // R11: entry went invalid, so a new erase wins again
        root_drive(0, RD, 0, 1, ER, A);
        compare("R11", t_up_vld, t_up_op, t_up_addr, t_dn_vld, t_dn_op, t_dn_addr, 0, 0, 0, 1, EX, A);
        idle_inputs();
        step();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule